// File: doc/BRIEF.md
# Two-Dice Roll Generator

This block turns an unpredictable hold time on a single enable line into a pair of die faces. While the roll enable is high, the block moves through every ordered pair of faces, one pair per clock. When the enable drops, the pair it has reached stays on the outputs. A person holds the enable for a length of time nobody can predict, so the pair it stops on is effectively random.

Two face counters are chained. The second die counts on every enabled clock. The first die counts only when the second die wraps from six back to one. This gives a period of 36 clocks, and each pair appears exactly once in that period. Alongside the faces, the block gives their sum and three decoded sum flags. A game controller next to the block uses these flags: one for a seven, one for a seven or eleven, and one for two, three or twelve. Debouncing of the button and the game rules belong to other blocks.

Top module: `dice_roller`

## Requirements
- R1: A synchronous active-high `rst` sets both faces to 1 on the next rising edge. It takes priority over `roll_en`.
- R2: While `roll_en` is 0 and `rst` is 0, neither face changes.
- R3: On each rising edge with `roll_en` = 1, `face_b` steps 1→2→3→4→5→6→1.
- R4: `face_a` increments by one, wrapping from 6 to 1, only on an enabled edge where `face_b` is 6. On all other edges it holds.
- R5: From pair (6,6), an enabled edge gives (1,1). Holding `roll_en` for N enabled edges moves the position index `(face_a-1)*6 + (face_b-1)` by exactly N mod 36.
- R6: `sum` is the unsigned 4-bit value `face_a + face_b`. It follows the registered faces combinationally, with no extra clock of delay.
- R7: `is_seven` is 1 exactly when the sum is 7.
- R8: `is_natural` is 1 exactly when the sum is 7 or 11.
- R9: `is_craps` is 1 exactly when the sum is 2, 3 or 12.
- R10: After reset, each face always lies in the range 1 to 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| roll_en | input | 1 | Advance the pair by one position per clock while high |
| face_a | output | 3 | First die face, 1 to 6, the slow counter |
| face_b | output | 3 | Second die face, 1 to 6, the fast counter |
| sum | output | 4 | face_a + face_b, 2 to 12 |
| is_seven | output | 1 | Sum equals 7 |
| is_natural | output | 1 | Sum equals 7 or 11 |
| is_craps | output | 1 | Sum equals 2, 3 or 12 |

## Verification
Several properties are checked on every cycle. Each face stays inside 1 to 6, and each face holds when it is not enabled. The fast face steps by one and wraps to one. The slow face moves only on the fast face's wrap, and (6,6) goes to (1,1). The flags must stay consistent with each other: seven implies natural, and craps never coincides with seven. Other behaviours come only from the bench's scenarios, which compare against an independent model on every clock. These are the exact values of the sum and of each flag over all 36 pairs, and the N mod 36 advance over long and broken-up enable runs. They also include reset winning over an active enable in the middle of a run.

// File: rtl/dice_pkg.sv
package dice_pkg;
  localparam int unsigned DEFAULT_FACES = 6;

  typedef struct packed {
    logic seven;
    logic natural;
    logic craps;
  } sum_flags_t;
endpackage

// File: rtl/dice_face_counter.sv
module dice_face_counter #(
  parameter int unsigned MAX = 6,
  parameter int unsigned W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] value,
  output logic         carry
);
  localparam logic [W-1:0] TOP = W'(MAX);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] val_q;
  logic         at_top;

  assign at_top = (val_q == TOP);
  assign carry  = en && at_top;
  assign value  = val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= ONE;
    end else if (en) begin
      val_q <= at_top ? ONE : val_q + ONE;
    end
  end

  // R10
  face_range_chk: assert property (@(posedge clk) disable iff (rst)
    (value >= ONE) && (value <= TOP));

  // R2
  face_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(value));

  // R3
  face_step_chk: assert property (@(posedge clk) disable iff (rst)
    en && (value != TOP) |=> value == $past(value) + ONE);

  // R3
  face_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    en && (value == TOP) |=> value == ONE);
endmodule

// File: rtl/dice_sum_decode.sv
module dice_sum_decode
  import dice_pkg::*;
#(
  parameter int unsigned MAX = 6,
  parameter int unsigned W   = $clog2(MAX + 1),
  parameter int unsigned SW  = $clog2(2 * MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [SW-1:0] total,
  output sum_flags_t    flags
);
  localparam logic [SW-1:0] SUM_SEVEN  = SW'(MAX + 1);
  localparam logic [SW-1:0] SUM_ELEVEN = SW'(2 * MAX - 1);
  localparam logic [SW-1:0] SUM_LOW0   = SW'(2);
  localparam logic [SW-1:0] SUM_LOW1   = SW'(3);
  localparam logic [SW-1:0] SUM_HIGH   = SW'(2 * MAX);

  always_comb begin
    total         = SW'(a) + SW'(b);
    flags.seven   = (total == SUM_SEVEN);
    flags.natural = (total == SUM_SEVEN) || (total == SUM_ELEVEN);
    flags.craps   = (total == SUM_LOW0) || (total == SUM_LOW1) ||
                    (total == SUM_HIGH);
  end

  // R8
  seven_natural_chk: assert property (@(posedge clk) disable iff (rst)
    flags.seven |-> flags.natural);

  // R9
  craps_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(flags.craps && flags.natural));

  // R6
  sum_range_chk: assert property (@(posedge clk) disable iff (rst)
    (total >= SUM_LOW0) && (total <= SUM_HIGH));
endmodule

// File: rtl/dice_roller.sv
module dice_roller
  import dice_pkg::*;
#(
  parameter int unsigned FACES = DEFAULT_FACES,
  parameter int unsigned W     = $clog2(FACES + 1),
  parameter int unsigned SW    = $clog2(2 * FACES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          roll_en,
  output logic [W-1:0]  face_a,
  output logic [W-1:0]  face_b,
  output logic [SW-1:0] sum,
  output logic          is_seven,
  output logic          is_natural,
  output logic          is_craps
);
  localparam logic [W-1:0] TOP = W'(FACES);
  localparam logic [W-1:0] ONE = W'(1);

  logic       b_carry;
  logic       a_carry;
  sum_flags_t flags;

  dice_face_counter #(.MAX(FACES), .W(W)) u_fast (
    .clk   (clk),
    .rst   (rst),
    .en    (roll_en),
    .value (face_b),
    .carry (b_carry)
  );

  dice_face_counter #(.MAX(FACES), .W(W)) u_slow (
    .clk   (clk),
    .rst   (rst),
    .en    (b_carry),
    .value (face_a),
    .carry (a_carry)
  );

  dice_sum_decode #(.MAX(FACES), .W(W), .SW(SW)) u_decode (
    .clk   (clk),
    .rst   (rst),
    .a     (face_a),
    .b     (face_b),
    .total (sum),
    .flags (flags)
  );

  assign is_seven   = flags.seven;
  assign is_natural = flags.natural;
  assign is_craps   = flags.craps;

  // R4
  slow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(roll_en && face_b == TOP) |=> $stable(face_a));

  // R5
  full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    roll_en && a_carry |=> (face_a == ONE) && (face_b == ONE));

  // R1
  reset_value_chk: assert property (@(posedge clk)
    rst |=> (face_a == ONE) && (face_b == ONE));
endmodule

// File: tb/test_dice_roller.sv
module test_dice_roller;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       roll_en = 1'b0;
  logic [2:0] face_a, face_b;
  logic [3:0] sum;
  logic       is_seven, is_natural, is_craps;

  int checks = 0;
  int fails  = 0;
  int ma = 1;
  int mb = 1;

  always #2 clk = ~clk;

  dice_roller i_dice_roller (
    .clk        (clk),
    .rst        (rst),
    .roll_en    (roll_en),
    .face_a     (face_a),
    .face_b     (face_b),
    .sum        (sum),
    .is_seven   (is_seven),
    .is_natural (is_natural),
    .is_craps   (is_craps)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int pos_of(input int a, input int b);
    return (a - 1) * 6 + (b - 1);
  endfunction

  task automatic compare_all();
    int s;
    s = ma + mb;
    chk("R4", face_a, ma);
    chk("R3", face_b, mb);
    chk("R10", int'(face_a >= 1 && face_a <= 6 && face_b >= 1 && face_b <= 6), 1);
    chk("R6", sum, s);
    chk("R7", is_seven, int'(s == 7));
    chk("R8", is_natural, int'(s == 7 || s == 11));
    chk("R9", is_craps, int'(s == 2 || s == 3 || s == 12));
  endtask

  task automatic cyc(input logic r, input logic e);
    rst = r;
    roll_en = e;
    @(posedge clk);
    if (r) begin
      ma = 1; mb = 1;
    end else if (e) begin
      if (mb == 6) begin
        mb = 1;
        ma = (ma == 6) ? 1 : ma + 1;
      end else begin
        mb = mb + 1;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_n(input int n);
    int start;
    start = pos_of(face_a, face_b);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1);
    chk("R5", pos_of(face_a, face_b), (start + n) % 36);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset wins over an active enable
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);
    chk("R1", face_a * 8 + face_b, 9);
    // R2: idle hold
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0);
    chk("R2", pos_of(face_a, face_b), 0);
    // R7 R8 R9: every pair once, back to start
    for (int i = 0; i < 36; i++) cyc(1'b0, 1'b1);
    chk("R5", face_a * 8 + face_b, 9);
    // broken-up enable pattern
    for (int k = 0; k < 60; k++) cyc(1'b0, (k % 3) != 0);
    for (int k = 0; k < 40; k++) cyc(1'b0, (k % 7) < 4);
    // R2: hold mid-sequence
    begin
      int here;
      here = pos_of(face_a, face_b);
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0);
      chk("R2", pos_of(face_a, face_b), here);
    end
    run_n(37);
    run_n(100);
    run_n(5);
    // R1: reset in the middle of a run
    cyc(1'b1, 1'b1);
    chk("R1", pos_of(face_a, face_b), 0);
    run_n(71);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule